// File: doc/BRIEF.md
# Quadrature Count Trigger Generator

This block turns a pair of quadrature phase signals (already single-ended) into a position count and a stream of timed trigger pulses. Each valid change of the two-bit phase state moves a wrapping up/down counter by one step. A separate signed distance register tracks net movement since the last trigger. When that distance reaches a configured number of steps in either direction, the block emits an active-low pulse that lasts a configured number of clock cycles.

The position counter runs at all times. An active-high enable decides only whether a trigger shows up on the output. A synchronous active-high clear returns the counter, the distance and the pulse logic to their idle state. The phase inputs go through two-flop synchronizers, so the system clock must run well above the fastest edge rate, which can reach several MHz. The step distance and the pulse length are elaboration parameters. Typical values are tens to a couple of hundred steps, and pulses of tens to hundreds of microseconds expressed in clocks.

Top module: `qtrig_top`

## Requirements
- R1: The phase state is {quad_a, quad_b}. The sequence 00→10→11→01→00 is forward, and each single-bit state change in that order raises `position` by one. The reverse order lowers it by one.
- R2: `position` wraps modulo 2^POS_W in both directions. Counting down by one from 0 gives all ones.
- R3: If both phase bits change between two synchronized samples, the change is invalid. It leaves `position` and the distance unchanged.
- R4: A trigger fires when the net signed movement since the last trigger or clear reaches +TRIG_STEPS or −TRIG_STEPS. Movement in the opposite direction cancels earlier movement, and each trigger restarts the distance at zero.
- R5: A trigger that starts a pulse holds `trig_n` low for exactly PULSE_CLKS consecutive clock cycles. Otherwise `trig_n` is high.
- R6: If `trig_en` is low in the cycle a trigger fires, no pulse is produced. The distance still restarts at zero.
- R7: A trigger that fires while a pulse is active is dropped. It does not lengthen or restart the pulse.
- R8: While `cnt_clr` is high, the next clock edge sets `position` to 0, drives `trig_n` high, cuts short any pulse in progress and sets the distance to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cnt_clr | input | 1 | Synchronous active-high clear of counter, distance and pulse |
| quad_a | input | 1 | Quadrature phase A, asynchronous |
| quad_b | input | 1 | Quadrature phase B, asynchronous |
| trig_en | input | 1 | Active-high gate for trigger output |
| trig_n | output | 1 | Active-low trigger pulse, registered |
| position | output | POS_W | Up/down position count, registered |

## Verification
The hardest condition to reach is a second trigger landing inside a pulse that is still active. At a relaxed step rate, TRIG_STEPS steps always take longer than the pulse, so this never happens. The bench therefore switches to one phase step per clock, which packs two triggers into a single pulse window, and then checks that only one pulse of normal width appears. It reaches the invalid double-bit transition by jumping the phase two states at once. It shows that reversing direction cancels earlier movement by running forward and backward by less than the step distance.

// File: rtl/qtrig_pkg.sv
package qtrig_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // forward successor of a phase state {a,b}: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] fwd_next(input logic [1:0] s);
    case (s)
      2'b00:   fwd_next = 2'b10;
      2'b10:   fwd_next = 2'b11;
      2'b11:   fwd_next = 2'b01;
      default: fwd_next = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qtrig_sync.sv
module qtrig_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      meta_q <= d_async[i];
      sync_q <= meta_q;
    end
    assign d_sync[i] = sync_q;
  end
endmodule

// File: rtl/qtrig_decode.sv
module qtrig_decode
  import qtrig_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] phase,
  output step_e      step
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= phase;
  end

  always_comb begin
    step = STEP_NONE;
    if (!clr) begin
      if (phase == fwd_next(prev_q))
        step = STEP_UP;
      else if (prev_q == fwd_next(phase))
        step = STEP_DOWN;
    end
  end
endmodule

// File: rtl/qtrig_pulse.sv
module qtrig_pulse #(
  parameter int PULSE_CLKS = 1000
) (
  input  logic clk,
  input  logic clr,
  input  logic fire,
  input  logic enable,
  output logic trig_n
);
  localparam int CW = $clog2(PULSE_CLKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CLKS);

  logic [CW-1:0] left_q, left_nxt;

  always_comb begin
    if (clr)
      left_nxt = '0;
    else if (left_q != '0)
      left_nxt = left_q - 1'b1;
    else if (fire && enable)
      left_nxt = LOAD;
    else
      left_nxt = '0;
  end

  always_ff @(posedge clk) begin
    left_q <= left_nxt;
    trig_n <= (left_nxt == '0);
  end
endmodule

// File: rtl/qtrig_top.sv
module qtrig_top
  import qtrig_pkg::*;
#(
  parameter int POS_W      = 24,
  parameter int TRIG_STEPS = 16,
  parameter int PULSE_CLKS = 1000
) (
  input  logic             clk,
  input  logic             cnt_clr,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             trig_en,
  output logic             trig_n,
  output logic [POS_W-1:0] position
);
  localparam int OFF_W = $clog2(TRIG_STEPS + 1) + 1;
  localparam logic signed [OFF_W-1:0] DIST_POS = OFF_W'(TRIG_STEPS);
  localparam logic signed [OFF_W-1:0] DIST_NEG = -DIST_POS;

  logic [1:0] phase_s;
  step_e      step;
  logic signed [OFF_W-1:0] dist_q, dist_nxt;
  logic       fire;

  qtrig_sync #(.W(2)) u_sync (
    .clk     (clk),
    .d_async ({quad_a, quad_b}),
    .d_sync  (phase_s)
  );

  qtrig_decode u_decode (
    .clk   (clk),
    .clr   (cnt_clr),
    .phase (phase_s),
    .step  (step)
  );

  always_comb begin
    case (step)
      STEP_UP:   dist_nxt = dist_q + OFF_W'(1);
      STEP_DOWN: dist_nxt = dist_q - OFF_W'(1);
      default:   dist_nxt = dist_q;
    endcase
    fire = (step != STEP_NONE) && ((dist_nxt == DIST_POS) || (dist_nxt == DIST_NEG));
  end

  always_ff @(posedge clk) begin
    if (cnt_clr) begin
      position <= '0;
      dist_q   <= '0;
    end else begin
      case (step)
        STEP_UP:   position <= position + 1'b1;
        STEP_DOWN: position <= position - 1'b1;
        default:   position <= position;
      endcase
      dist_q <= fire ? '0 : dist_nxt;
    end
  end

  qtrig_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk    (clk),
    .clr    (cnt_clr),
    .fire   (fire),
    .enable (trig_en),
    .trig_n (trig_n)
  );
endmodule

// File: rtl/qtrig_checker.sv
module qtrig_checker #(
  parameter int POS_W      = 24,
  parameter int PULSE_CLKS = 1000
) (
  input logic             clk,
  input logic             cnt_clr,
  input logic             trig_en,
  input logic             trig_n,
  input logic [POS_W-1:0] position
);
  localparam int LW = $clog2(PULSE_CLKS + 2) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (cnt_clr || trig_n) low_run <= '0;
    else                   low_run <= low_run + 1'b1;
  end

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (cnt_clr)
    ($rose(trig_n) && !$past(cnt_clr)) |-> (low_run == LW'(PULSE_CLKS)));

  a_r7_no_stretch: assert property (@(posedge clk) disable iff (cnt_clr)
    !trig_n |-> (low_run < LW'(PULSE_CLKS)));

  a_r6_gated_start: assert property (@(posedge clk) disable iff (cnt_clr)
    ($fell(trig_n) && !$past(cnt_clr)) |-> $past(trig_en));

  a_r4_fire_on_move: assert property (@(posedge clk) disable iff (cnt_clr)
    ($fell(trig_n) && !$past(cnt_clr)) |-> (position != $past(position)));

  a_r1_single_step: assert property (@(posedge clk) disable iff (cnt_clr)
    !$past(cnt_clr) |-> ((position == $past(position)) ||
                         (position == $past(position) + POS_W'(1)) ||
                         (position == $past(position) - POS_W'(1))));

  a_r8_clear: assert property (@(posedge clk)
    cnt_clr |=> ((position == '0) && trig_n));
endmodule

bind qtrig_top qtrig_checker #(.POS_W(POS_W), .PULSE_CLKS(PULSE_CLKS)) u_qtrig_checker (
  .clk      (clk),
  .cnt_clr  (cnt_clr),
  .trig_en  (trig_en),
  .trig_n   (trig_n),
  .position (position)
);

// File: tb/qtrig_top_bench.sv
`timescale 1ns/1ps
module qtrig_top_bench;
  localparam int POS_W = 24;
  localparam int XSTEP = 5;
  localparam int PCLK  = 6;
  localparam int NV    = 9;

  // entry: {up[13], steps[12:5], en[4], pulses[3:0]}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 8'd5,  1'b1, 4'd1},
    {1'b1, 8'd4,  1'b1, 4'd0},
    {1'b0, 8'd4,  1'b1, 4'd0},
    {1'b0, 8'd5,  1'b1, 4'd1},
    {1'b0, 8'd12, 1'b1, 4'd2},
    {1'b1, 8'd2,  1'b0, 4'd0},
    {1'b1, 8'd5,  1'b0, 4'd0},
    {1'b1, 8'd5,  1'b1, 4'd1},
    {1'b1, 8'd15, 1'b1, 4'd3}
  };

  logic clk = 1'b0;
  logic cnt_clr, quad_a, quad_b, trig_en;
  logic trig_n;
  logic [POS_W-1:0] position;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int run    = 0;
  bit in_low = 1'b0;
  int ph     = 0;
  logic [POS_W-1:0] exp_pos = '0;

  always #5 clk = ~clk;

  qtrig_top #(.POS_W(POS_W), .TRIG_STEPS(XSTEP), .PULSE_CLKS(PCLK)) u_qtrig_top (
    .clk(clk), .cnt_clr(cnt_clr), .quad_a(quad_a), .quad_b(quad_b),
    .trig_en(trig_en), .trig_n(trig_n), .position(position)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse monitor: counts pulses and checks each width (R5)
  always @(negedge clk) begin
    if (cnt_clr) begin
      in_low = 1'b0;
      run    = 0;
    end else if (trig_n === 1'b0) begin
      if (!in_low) begin
        pulses++;
        in_low = 1'b1;
        run    = 1;
      end else run++;
    end else if (in_low) begin
      chk(run == PCLK, "R5 pulse width", run, PCLK);
      in_low = 1'b0;
    end
  end

  function automatic logic [1:0] ph_bits(input int p);
    case (p & 3)
      0: ph_bits = 2'b00;
      1: ph_bits = 2'b10;
      2: ph_bits = 2'b11;
      default: ph_bits = 2'b01;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic move(input bit up, input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      ph = up ? ph + 1 : ph + 3;
      {quad_a, quad_b} = ph_bits(ph);
      exp_pos = up ? exp_pos + 1'b1 : exp_pos - 1'b1;
      wait_cyc(hold);
    end
  endtask

  task automatic do_clear();
    cnt_clr = 1'b1;
    wait_cyc(1);
    cnt_clr = 1'b0;
    exp_pos = '0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    cnt_clr = 1'b1; quad_a = 1'b0; quad_b = 1'b0; trig_en = 1'b0;
    wait_cyc(5);
    cnt_clr = 1'b0;
    wait_cyc(1);
    chk(trig_n == 1'b1, "R8 reset trig_n high", trig_n, 1);
    chk(position == '0, "R8 reset position zero", position, 0);

    // table walk: R1 direction, R2 wrap, R4 net distance, R6 gating
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      trig_en = VEC[v][4];
      move(VEC[v][13], int'(VEC[v][12:5]), 4);
      wait_cyc(12);
      chk(position == exp_pos, "R1/R2 position after vector", position, exp_pos);
      chk(pulses - p0 == int'(VEC[v][3:0]), "R4/R6 pulse count per vector",
          pulses - p0, VEC[v][3:0]);
    end

    // R2: wrap below zero gives all ones
    do_clear();
    move(1'b0, 1, 4);
    wait_cyc(4);
    chk(position == {POS_W{1'b1}}, "R2 wrap to all ones", position, {POS_W{1'b1}});
    move(1'b1, 1, 4);
    wait_cyc(4);
    chk(position == '0, "R2 wrap back to zero", position, 0);

    // R3: double-bit jump ignored (there and back)
    p0 = pulses;
    move(1'b1, 3, 4);
    wait_cyc(4);
    ph = ph + 2; {quad_a, quad_b} = ph_bits(ph); wait_cyc(6);
    chk(position == exp_pos, "R3 invalid jump ignored", position, exp_pos);
    ph = ph + 2; {quad_a, quad_b} = ph_bits(ph); wait_cyc(6);
    chk(position == exp_pos, "R3 invalid jump back ignored", position, exp_pos);
    move(1'b1, 2, 4);
    wait_cyc(12);
    chk(pulses - p0 == 1, "R3 distance unchanged by jumps", pulses - p0, 1);

    // R8: clear mid-pulse
    do_clear();
    trig_en = 1'b1;
    move(1'b1, XSTEP, 1);
    wait_cyc(3);
    chk(trig_n == 1'b0, "R8 pulse active before clear", trig_n, 0);
    do_clear();
    chk(trig_n == 1'b1, "R8 clear ends pulse", trig_n, 1);
    chk(position == '0, "R8 clear zeroes position", position, 0);
    wait_cyc(10);

    // R7: two triggers inside one pulse window
    p0 = pulses;
    move(1'b1, 2 * XSTEP, 1);
    wait_cyc(16);
    chk(pulses - p0 == 1, "R7 retrigger absorbed", pulses - p0, 1);
    chk(position == exp_pos, "R1 fast stepping position", position, exp_pos);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule